// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block holds the time of day and the calendar date as packed BCD bytes and moves them forward by one second each time a one-cycle `tick` enable arrives from an upstream 1 Hz prescaler. A carry from the seconds ripples through minutes and hours (24-hour form), then advances the weekday and the date. The date wraps at the true end of each month, with February lengthened in leap years. The month carries into a two-digit year, and a rollover from year 99 to 00 flips a century flag.

A bus-side agent can overwrite any single field through a write port: a select code picks the field and a data byte supplies the value. All fields are always readable on their own output ports, each byte zero-filled above the bits the field uses. Written values are taken as they are and are not range-checked.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 00, weekday reads 1, date and month read 01, and the century flag reads 0.
- R2: On each cycle with `tick` high and `wr_en` low, seconds step by one in BCD from 00 to 59 and then wrap to 00. Without `tick` no field changes.
- R3: Minutes step by one (00 to 59, wrapping to 00) only on a tick that wraps the seconds.
- R4: Hours step by one (00 to 23, wrapping to 00) only on a tick that wraps both minutes and seconds.
- R5: The weekday steps 1 to 7 and then back to 1, and the date steps by one, each on a tick that wraps the hours.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12. On that wrap the month steps by one.
- R7: In month 02 the date wraps after 29 when the year is a leap year, and after 28 otherwise. A BCD year is a leap year when its tens digit is even and its units digit is 0, 4 or 8, or when the tens digit is odd and the units digit is 2 or 6.
- R8: Month wraps from 12 to 01, and on that wrap the year steps by one.
- R9: When the year wraps from 99 to 00, the century flag inverts. No other tick changes it.
- R10: With `wr_en` high, `wr_sel` chooses the field written on that clock edge: 0 seconds (`wr_data[6:0]`), 1 minutes (`[6:0]`), 2 hours (`[5:0]`) together with the century flag (`[6]`), 3 weekday (`[2:0]`), 4 date (`[5:0]`), 5 month (`[4:0]`), 6 year (`[7:0]`).
- R11: A write takes priority over `tick` in the same cycle. The tick of that cycle is dropped, so a written seconds value is kept unchanged for that edge.
- R12: A write with `wr_sel` = 7 changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable, one per second |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Field write value (packed BCD) |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, 24-hour form |
| cent_o | output | 1 | Century flag |
| dow_o | output | 8 | Weekday 1 to 7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
The bench steers the calendar onto the month-end edges: 30-day and 31-day months, February in years 23, 24 and 00, and the last second of year 99. A wrong month-length table or a faulty leap decode would show up there as a date of 31 in April, or as a missing or extra 29 February. A missing century toggle, or one that fires on every year wrap, is caught across two consecutive 99-to-00 rollovers. Writes issued in the same cycle as a tick expose a design that lets the increment win, and a select-7 write exposes a decoder that leaks into some field. A long run with a tick on every cycle compares every field against a behavioural model clock by clock, which catches BCD digit-carry errors such as 0A or 60 appearing.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       cent_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [7:0] sec, mins, hour, dow, date, month, year;
  logic       cent;

  logic leap;
  assign leap = year[4] ? (year[3:0] == 4'd2 || year[3:0] == 4'd6)
                        : (year[3:0] == 4'd0 || year[3:0] == 4'd4 || year[3:0] == 4'd8);

  logic [7:0] last_day;
  always_comb begin
    case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap, y_wrap;
  assign s_wrap  = sec >= 8'h59;
  assign m_wrap  = s_wrap && mins >= 8'h59;
  assign h_wrap  = m_wrap && hour >= 8'h23;
  assign d_wrap  = h_wrap && date >= last_day;
  assign mo_wrap = d_wrap && month >= 8'h12;
  assign y_wrap  = mo_wrap && year >= 8'h99;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec   <= 8'h00;
      mins  <= 8'h00;
      hour  <= 8'h00;
      cent  <= 1'b0;
      dow   <= 8'h01;
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: sec   <= {1'b0, wr_data[6:0]};
        3'd1: mins  <= {1'b0, wr_data[6:0]};
        3'd2: begin
          hour <= {2'b0, wr_data[5:0]};
          cent <= wr_data[6];
        end
        3'd3: dow   <= {5'b0, wr_data[2:0]};
        3'd4: date  <= {2'b0, wr_data[5:0]};
        3'd5: month <= {3'b0, wr_data[4:0]};
        3'd6: year  <= wr_data;
        default: ;
      endcase
    end else if (tick) begin
      sec <= s_wrap ? 8'h00 : bcd_inc(sec);
      if (s_wrap) mins <= m_wrap ? 8'h00 : bcd_inc(mins);
      if (m_wrap) hour <= h_wrap ? 8'h00 : bcd_inc(hour);
      if (h_wrap) begin
        dow  <= (dow >= 8'h07) ? 8'h01 : dow + 8'h01;
        date <= d_wrap ? 8'h01 : bcd_inc(date);
      end
      if (d_wrap)  month <= mo_wrap ? 8'h01 : bcd_inc(month);
      if (mo_wrap) year  <= y_wrap ? 8'h00 : bcd_inc(year);
      if (y_wrap)  cent  <= ~cent;
    end
  end

  assign sec_o   = sec;
  assign min_o   = mins;
  assign hour_o  = hour;
  assign cent_o  = cent;
  assign dow_o   = dow;
  assign date_o  = date;
  assign month_o = month;
  assign year_o  = year;

endmodule

module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic       cent_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o
);

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && sec_o == 8'h59 |=> sec_o == 8'h00);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_en |=> $stable(sec_o) && $stable(min_o) && $stable(date_o));

  p_min_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && sec_o != 8'h59 |=> $stable(min_o));

  p_dow_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23
    |=> dow_o != $past(dow_o));

  p_cent_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && !wr_en && year_o == 8'h99) && !(wr_en && wr_sel == 3'd2) |=> $stable(cent_o));

  p_wr_sec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 3'd0 |=> sec_o == {1'b0, $past(wr_data[6:0])});

  p_sel7_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 3'd7 |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o)
      && $stable(cent_o) && $stable(dow_o) && $stable(date_o) && $stable(month_o)
      && $stable(year_o));

endmodule

bind bcd_calendar bcd_calendar_chk u_chk (.*);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic cent_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  int ms, mm, mh, mc, mdw, md, mmo, my;

  always #(PERIOD/2) clk = ~clk;

  bcd_calendar u_bcd_calendar (.*);

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic int days_in(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mm = 0; mh = 0; mc = 0; mdw = 1; md = 1; mmo = 1; my = 0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: ms = from_bcd({1'b0, wr_data[6:0]});
        3'd1: mm = from_bcd({1'b0, wr_data[6:0]});
        3'd2: begin mh = from_bcd({2'b0, wr_data[5:0]}); mc = int'(wr_data[6]); end
        3'd3: mdw = int'(wr_data[2:0]);
        3'd4: md = from_bcd({2'b0, wr_data[5:0]});
        3'd5: mmo = from_bcd({3'b0, wr_data[4:0]});
        3'd6: my = from_bcd(wr_data);
        default: ;
      endcase
    end else if (tick) begin
      ms++;
      if (ms == 60) begin
        ms = 0; mm++;
        if (mm == 60) begin
          mm = 0; mh++;
          if (mh == 24) begin
            mh = 0;
            mdw = (mdw == 7) ? 1 : mdw + 1;
            md++;
            if (md > days_in(mmo, my)) begin
              md = 1; mmo++;
              if (mmo == 13) begin
                mmo = 1; my++;
                if (my == 100) begin my = 0; mc = 1 - mc; end
              end
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 seconds", sec_o, to_bcd(ms));
      check("R3 minutes", min_o, to_bcd(mm));
      check("R4 hours", hour_o, to_bcd(mh));
      check("R5 weekday", dow_o, to_bcd(mdw));
      check("R6 R7 date", date_o, to_bcd(md));
      check("R8 month", month_o, to_bcd(mmo));
      check("R8 year", year_o, to_bcd(my));
      check("R9 century", {7'b0, cent_o}, 8'(mc));
    end
  end

  task automatic drive(input logic t, input logic w, input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    tick = t; wr_en = w; wr_sel = s; wr_data = d;
  endtask

  task automatic put(input logic [2:0] s, input logic [7:0] d);
    drive(1'b0, 1'b1, s, d);
  endtask

  task automatic set_all(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                         input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se);
    put(3'd6, yr); put(3'd5, mo); put(3'd4, dt);
    put(3'd2, hr); put(3'd1, mi); put(3'd0, se);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 3'd0, 8'h00);
    drive(1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sec", sec_o, 8'h00);
    check("R1 hour", hour_o, 8'h00);
    check("R1 dow", dow_o, 8'h01);
    check("R1 date", date_o, 8'h01);
    check("R1 month", month_o, 8'h01);
    check("R1 cent", {7'b0, cent_o}, 8'h00);

    // R2 R3 sparse ticks
    for (int i = 0; i < 150; i++) drive(i % 3 == 0, 1'b0, 3'd0, 8'h00);
    ticks(130);

    // R4 R5 R6 April 30 -> May 1, weekday 7 -> 1
    set_all(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h58);
    put(3'd3, 8'h07);
    ticks(3);
    check("R6 april end", date_o, 8'h01);
    check("R5 dow wrap", dow_o, 8'h01);

    // R6 May 31 -> June 1
    set_all(8'h23, 8'h05, 8'h31, 8'h23, 8'h59, 8'h59);
    ticks(1);
    check("R6 may end", month_o, 8'h06);

    // R7 Feb in leap 24, non-leap 23, leap 00
    set_all(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    ticks(1);
    check("R7 leap 24 feb29", date_o, 8'h29);
    put(3'd2, 8'h23); put(3'd1, 8'h59); put(3'd0, 8'h59);
    ticks(1);
    check("R7 leap 24 mar", month_o, 8'h03);
    set_all(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    ticks(1);
    check("R7 year 23 mar", month_o, 8'h03);
    set_all(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    ticks(1);
    check("R7 year 00 feb29", date_o, 8'h29);
    set_all(8'h96, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    ticks(1);
    check("R7 year 96 feb29", date_o, 8'h29);

    // R8 R9 year end twice
    set_all(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    ticks(1);
    check("R9 cent set", {7'b0, cent_o}, 8'h01);
    check("R8 year wrap", year_o, 8'h00);
    set_all(8'h99, 8'h12, 8'h31, 8'h63, 8'h59, 8'h59);
    ticks(1);
    check("R9 cent clear", {7'b0, cent_o}, 8'h00);

    // R10 hour byte carries century
    put(3'd2, 8'h45);
    drive(1'b0, 1'b0, 3'd0, 8'h00);
    check("R10 hour", hour_o, 8'h05);
    check("R10 cent", {7'b0, cent_o}, 8'h01);

    // R11 write beats tick
    drive(1'b1, 1'b1, 3'd0, 8'h10);
    drive(1'b0, 1'b0, 3'd0, 8'h00);
    check("R11 sec kept", sec_o, 8'h10);

    // R12 select 7 ignored
    put(3'd7, 8'h55);
    drive(1'b0, 1'b0, 3'd0, 8'h00);
    check("R12 sec", sec_o, 8'h10);
    check("R12 year", year_o, 8'h00);

    ticks(90000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule